// File: doc/BRIEF.md
# Indirect I/O Tunnel Window

This block is a host-side register window. It lets a host reach I/O registers and configuration registers that sit behind a bridge, without mapping them directly. The host first loads a 32-bit target address into an address register. Each later access to the data register turns into exactly one 32-bit downstream cycle at that address. The address register keeps its value between accesses, so a driver can hit the same target again and again without reloading it.

A one-shot flag changes the kind of cycle. When it is armed, the very next data-register access becomes a configuration cycle instead of an I/O cycle, and the flag then clears itself. The window covers 1 KB of host I/O space, but only 48 bytes are decoded. Any offset is folded modulo 48, so those 48 bytes repeat across the whole window.

By convention, the downstream I/O space sits 0x1000 above the host base. For example, a host base of 0x1C00 pairs with a downstream base of 0x2C00. Software therefore writes addresses such as 0x2C14 into the address register, and the block passes that value through to the downstream bus unchanged.

Both the host request channel and the downstream channel use valid/ready:
- A transfer happens on a clock edge where valid and ready are both high.
- A master that raises valid keeps it high, and keeps its payload stable, until ready is seen.
- Host read data is valid in the cycle of the host handshake.
- Downstream read data is valid in the cycle of the downstream handshake.
- Writes to the data register are posted into a single-entry buffer.
- Reads of the data register hold host_ready low until the downstream cycle completes.

Top module: `tunnel_window`

## Requirements
- R1: After reset the address register reads 0, the configuration flag is disarmed, and dn_valid is low.
- R2: Host offset 0x08 is a 32-bit read/write address register. Its value is kept unchanged across data-register accesses and across accesses to other offsets.
- R3: A host write to offset 0x0C is accepted in its first cycle when the post buffer is empty. From the next cycle on, the block presents a downstream request with dn_write=1, dn_addr equal to the address register and dn_wdata equal to the written data.
- R4: A host read of offset 0x0C, with the post buffer empty, presents a downstream read (dn_write=0, dn_wdata=0) in the same cycle. host_ready is asserted only in the cycle in which dn_ready is high, and host_rdata then equals dn_rdata.
- R5: While a posted write is still waiting downstream, any host access to offset 0x0C is stalled (host_ready low). Downstream cycles occur in host acceptance order.
- R6: A host write to offset 0x04 with bit 0 set arms the configuration flag, and a write with bit 0 clear disarms it. Only the next accepted data-register access carries dn_cfg=1, after which the flag clears. A read of offset 0x04 returns 0.
- R7: The offset is taken modulo 48 with bits [1:0] ignored, across the full 1 KB window. For example, 0x3F8 and 0x38 address the address register, 0x3FC addresses the data register, and 0x34 addresses the configuration flag.
- R8: Offsets other than 0x04, 0x08 and 0x0C (after folding) accept immediately, read as 0, and ignore writes.
- R9: While dn_valid is high and dn_ready is low, dn_valid stays high and dn_addr, dn_write, dn_cfg and dn_wdata stay stable. Each downstream handshake corresponds to exactly one accepted data-register access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request valid |
| host_ready | output | 1 | Host access accepted this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Byte offset within the host window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid on handshake |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream acknowledge |
| dn_write | output | 1 | Downstream write (1) or read (0) |
| dn_cfg | output | 1 | Downstream configuration cycle (1) or I/O cycle (0) |
| dn_addr | output | 32 | Downstream target address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid on handshake |

## Verification
The bench builds the block with its default 1 KB window and 48 implemented bytes. Because 48 is not a power of two, the fold is a true modulo rather than a bit mask. That puts the alias cases at offsets 0x34, 0x38, 0x3F8 and 0x3FC within reach, and those cases would expose a masking decode. The bench also varies the downstream acknowledge latency from zero to three cycles. With that range it covers single-cycle reads, read stalls of a known length, and a second posted write that must wait until the first one drains.

// File: rtl/tunnel_pkg.sv
package tunnel_pkg;

  // Downstream bus width. It is fixed at 32 bits because the downstream side
  // has no narrower access mode.
  localparam int unsigned DATA_W = 32;

  // Decoded register offsets inside the folded window.
  localparam int unsigned OFF_CFG  = 4;
  localparam int unsigned OFF_ADDR = 8;
  localparam int unsigned OFF_DATA = 12;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_ADDR,
    SEL_DATA
  } reg_sel_e;

  typedef struct packed {
    logic              write;
    logic              cfg;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } dn_req_t;

endpackage

// File: rtl/tunnel_decode.sv
module tunnel_decode
  import tunnel_pkg::*;
#(
  parameter int unsigned AW         = 10,
  parameter int unsigned IMPL_BYTES = 48
) (
  input  logic [AW-1:0] offset,
  output reg_sel_e      sel
);

  // Offset constants at the width of the folded offset.
  localparam logic [AW-1:0] K_CFG  = AW'(OFF_CFG);
  localparam logic [AW-1:0] K_ADDR = AW'(OFF_ADDR);
  localparam logic [AW-1:0] K_DATA = AW'(OFF_DATA);

  logic [AW-1:0] folded;
  logic [AW-1:0] word_off;

  always_comb begin
    // Fold the offset into the implemented bytes, then drop the byte lane bits.
    folded   = offset % AW'(IMPL_BYTES);
    word_off = {folded[AW-1:2], 2'b00};

    if (word_off == K_CFG) begin
      sel = SEL_CFG;
    end else if (word_off == K_ADDR) begin
      sel = SEL_ADDR;
    end else if (word_off == K_DATA) begin
      sel = SEL_DATA;
    end else begin
      sel = SEL_NONE;
    end
  end

endmodule

// File: rtl/tunnel_post_buf.sv
module tunnel_post_buf
  import tunnel_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  dn_req_t push_req,
  input  logic    pop,
  output logic    full,
  output dn_req_t held
);

  // Single-entry holding register for one posted write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (push) begin
      full <= 1'b1;
      held <= push_req;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/tunnel_window.sv
module tunnel_window
  import tunnel_pkg::*;
#(
  parameter int unsigned WIN_BYTES  = 1024,
  parameter int unsigned IMPL_BYTES = 48
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            host_valid,
  output logic                            host_ready,
  input  logic                            host_write,
  input  logic [$clog2(WIN_BYTES)-1:0]    host_addr,
  input  logic [tunnel_pkg::DATA_W-1:0]   host_wdata,
  output logic [tunnel_pkg::DATA_W-1:0]   host_rdata,
  output logic                            dn_valid,
  input  logic                            dn_ready,
  output logic                            dn_write,
  output logic                            dn_cfg,
  output logic [tunnel_pkg::DATA_W-1:0]   dn_addr,
  output logic [tunnel_pkg::DATA_W-1:0]   dn_wdata,
  input  logic [tunnel_pkg::DATA_W-1:0]   dn_rdata
);

  localparam int unsigned AW = $clog2(WIN_BYTES);

  reg_sel_e          sel;
  logic [DATA_W-1:0] addr_q;
  logic              armed_q;
  logic              buf_full;
  dn_req_t           buf_req;
  dn_req_t           live_req;
  dn_req_t           out_req;
  logic              data_acc;
  logic              rd_live;
  logic              wr_push;
  logic              accept;

  tunnel_decode #(
    .AW        (AW),
    .IMPL_BYTES(IMPL_BYTES)
  ) u_decode (
    .offset(host_addr),
    .sel   (sel)
  );

  // Classify the current host request.
  always_comb begin
    data_acc = host_valid && (sel == SEL_DATA);
    rd_live  = data_acc && !host_write && !buf_full;
    wr_push  = data_acc && host_write && !buf_full;
  end

  // Host-side ready: register offsets finish at once, data offsets depend on
  // the post buffer and on the downstream acknowledge.
  always_comb begin
    if (sel == SEL_DATA) begin
      if (host_write) begin
        host_ready = !buf_full;
      end else begin
        host_ready = !buf_full && dn_ready;
      end
    end else begin
      host_ready = 1'b1;
    end
  end

  assign accept = host_valid && host_ready;

  // Request built from the current host access and the address register.
  always_comb begin
    live_req.write = host_write;
    live_req.cfg   = armed_q;
    live_req.addr  = addr_q;
    live_req.wdata = host_write ? host_wdata : '0;
  end

  tunnel_post_buf u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (wr_push),
    .push_req(live_req),
    .pop     (buf_full && dn_ready),
    .full    (buf_full),
    .held    (buf_req)
  );

  // A waiting posted write owns the downstream bus; otherwise a live read passes through.
  always_comb begin
    out_req  = buf_full ? buf_req : live_req;
    dn_valid = buf_full || rd_live;
    dn_write = out_req.write;
    dn_cfg   = out_req.cfg;
    dn_addr  = out_req.addr;
    dn_wdata = out_req.wdata;
  end

  // Address register and one-shot configuration flag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      armed_q <= 1'b0;
    end else if (accept) begin
      if (host_write && sel == SEL_ADDR) begin
        addr_q <= host_wdata;
      end
      if (sel == SEL_DATA) begin
        armed_q <= 1'b0;
      end else if (host_write && sel == SEL_CFG) begin
        armed_q <= host_wdata[0];
      end
    end
  end

  // Read-back mux; the flag and unused offsets read as zero.
  always_comb begin
    case (sel)
      SEL_ADDR: host_rdata = addr_q;
      SEL_DATA: host_rdata = dn_rdata;
      default:  host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tunnel_window_chk.sv
module tunnel_window_chk #(
  parameter int unsigned WIN_BYTES  = 1024,
  parameter int unsigned IMPL_BYTES = 48
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           host_valid,
  input logic                           host_ready,
  input logic                           host_write,
  input logic [$clog2(WIN_BYTES)-1:0]   host_addr,
  input logic [31:0]                    host_wdata,
  input logic [31:0]                    host_rdata,
  input logic                           dn_valid,
  input logic                           dn_ready,
  input logic                           dn_write,
  input logic                           dn_cfg,
  input logic [31:0]                    dn_addr,
  input logic [31:0]                    dn_wdata,
  input logic [31:0]                    dn_rdata,
  input logic [31:0]                    addr_q
);

  localparam int unsigned AW = $clog2(WIN_BYTES);

  logic [AW-1:0] chk_off;
  logic          is_data_c;
  logic          is_addr_c;

  always_comb begin
    chk_off   = host_addr % AW'(IMPL_BYTES);
    is_data_c = (chk_off >= AW'(12)) && (chk_off < AW'(16));
    is_addr_c = (chk_off >= AW'(8))  && (chk_off < AW'(12));
  end

  // R8: non-data offsets never stall
  p_reg_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && !is_data_c |-> host_ready);

  // R8, R6: only the address register and the data register return nonzero data
  p_zero_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && !host_write && !is_data_c && !is_addr_c |-> host_rdata == '0);

  // R4: a data read completes only together with a downstream read handshake
  p_read_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && !host_write && is_data_c && host_ready
      |-> dn_valid && dn_ready && !dn_write && host_rdata == dn_rdata);

  // R3: an accepted data write appears downstream in the next cycle
  p_post_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_write && is_data_c && host_ready
      |=> dn_valid && dn_write && dn_wdata == $past(host_wdata) && dn_addr == $past(addr_q));

  // R5: a waiting posted write blocks further data accesses
  p_stall_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_write && !dn_ready && host_valid && is_data_c |-> !host_ready);

  // R9: downstream request is held stable until acknowledged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready
      |=> dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_cfg) && $stable(dn_wdata));

  // R2: the address register changes only on a write to its offset
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_ready && host_write && is_addr_c) |=> $stable(addr_q));

endmodule

bind tunnel_window tunnel_window_chk #(
  .WIN_BYTES (WIN_BYTES),
  .IMPL_BYTES(IMPL_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_valid(host_valid),
  .host_ready(host_ready),
  .host_write(host_write),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .host_rdata(host_rdata),
  .dn_valid  (dn_valid),
  .dn_ready  (dn_ready),
  .dn_write  (dn_write),
  .dn_cfg    (dn_cfg),
  .dn_addr   (dn_addr),
  .dn_wdata  (dn_wdata),
  .dn_rdata  (dn_rdata),
  .addr_q    (addr_q)
);

// File: tb/test_tunnel_window.sv
module test_tunnel_window;
  import tunnel_pkg::*;

  localparam int WIN  = 1024;
  localparam int IMPL = 48;
  localparam int AW   = $clog2(WIN);

  logic          clk;
  logic          rst_n;
  logic          host_valid;
  logic          host_ready;
  logic          host_write;
  logic [AW-1:0] host_addr;
  logic [31:0]   host_wdata;
  logic [31:0]   host_rdata;
  logic          dn_valid;
  logic          dn_ready;
  logic          dn_write;
  logic          dn_cfg;
  logic [31:0]   dn_addr;
  logic [31:0]   dn_wdata;
  logic [31:0]   dn_rdata;

  tunnel_window #(.WIN_BYTES(WIN), .IMPL_BYTES(IMPL)) i_tunnel_window (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write), .dn_cfg(dn_cfg),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int      vecs = 0;
  int      miss = 0;
  dn_req_t exp_q[$];
  int      lat = 0;
  int      cnt = 0;
  bit      hs_pend = 0;
  logic [31:0] exp_addr = '0;
  bit      exp_armed = 0;

  // Downstream read data is derived from the request so the bench can predict it.
  function automatic logic [31:0] model_rd(input logic [31:0] a, input logic c);
    return a ^ (c ? 32'hC0F1_6000 : 32'h5A5A_0000);
  endfunction
  assign dn_rdata = model_rd(dn_addr, dn_cfg);

  function automatic int fold(input logic [AW-1:0] a);
    return (int'(a) % IMPL) & ~3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Downstream responder: acknowledge after lat waiting cycles.
  always @(negedge clk) begin
    #1;
    if (hs_pend) begin
      cnt = 0;
      hs_pend = 0;
    end
    if (dn_valid && cnt >= lat) begin
      dn_ready = 1'b1;
    end else begin
      dn_ready = 1'b0;
      if (dn_valid) cnt++;
      else cnt = 0;
    end
  end

  // Scoreboard monitor: each downstream handshake pops one expected item (R9).
  always @(negedge clk) begin
    #2;
    if (rst_n && dn_valid && dn_ready) begin
      hs_pend = 1;
      if (exp_q.size() == 0) begin
        check("R9 unexpected downstream cycle", 32'd1, 32'd0);
      end else begin
        dn_req_t e;
        string tag;
        e = exp_q.pop_front();
        tag = e.cfg ? "R6 cfg cycle" : (e.write ? "R3 posted write" : "R4 read cycle");
        check({tag, " write"}, {31'd0, dn_write}, {31'd0, e.write});
        check({tag, " cfg"},   {31'd0, dn_cfg},   {31'd0, e.cfg});
        check({tag, " addr"},  dn_addr,  e.addr);
        check({tag, " wdata"}, dn_wdata, e.wdata);
      end
    end
  end

  task automatic hacc(input bit wr, input logic [AW-1:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int waits);
    @(negedge clk);
    host_valid = 1'b1;
    host_write = wr;
    host_addr  = a;
    host_wdata = wd;
    waits = 0;
    #2;
    while (!host_ready) begin
      @(negedge clk);
      #2;
      waits++;
    end
    rd = host_rdata;
    @(posedge clk);
    #1;
    host_valid = 1'b0;
    host_write = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] wd, output int waits);
    logic [31:0] rd;
    dn_req_t e;
    int f;
    f = fold(a);
    if (f == 12) begin
      e.write = 1'b1; e.cfg = exp_armed; e.addr = exp_addr; e.wdata = wd;
      exp_q.push_back(e);
      exp_armed = 0;
    end else if (f == 8) begin
      exp_addr = wd;
    end else if (f == 4) begin
      exp_armed = wd[0];
    end
    hacc(1'b1, a, wd, rd, waits);
  endtask

  task automatic do_read(input string tag, input logic [AW-1:0] a, output int waits);
    logic [31:0] rd;
    logic [31:0] exp;
    dn_req_t e;
    int f;
    f = fold(a);
    if (f == 12) begin
      e.write = 1'b0; e.cfg = exp_armed; e.addr = exp_addr; e.wdata = '0;
      exp_q.push_back(e);
      exp = model_rd(exp_addr, exp_armed);
      exp_armed = 0;
    end else if (f == 8) begin
      exp = exp_addr;
    end else begin
      exp = '0;
    end
    hacc(1'b0, a, '0, rd, waits);
    check(tag, rd, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    int w;
    rst_n = 1'b0; host_valid = 1'b0; host_write = 1'b0;
    host_addr = '0; host_wdata = '0; dn_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    check("R1 dn_valid after reset", {31'd0, dn_valid}, 32'd0);
    do_read("R1 address register reset value", 10'h008, w);
    do_read("R6 flag reads zero after reset", 10'h004, w);

    // R2: address register read/write
    lat = 0;
    do_write(10'h008, 32'h0000_2C14, w);
    do_read("R2 address register readback", 10'h008, w);

    // R3: posted write accepted in first cycle
    do_write(10'h00C, 32'hDEAD_BEEF, w);
    check("R3 posted write accept waits", w, 0);
    repeat (2) @(negedge clk);

    // R4: read waits for downstream acknowledge
    lat = 2;
    do_read("R4 data read value", 10'h00C, w);
    check("R4 read stall cycles", w, 2);
    lat = 0;
    do_read("R4 zero-latency data read", 10'h00C, w);
    check("R4 zero-latency stall cycles", w, 0);
    do_read("R2 address held after data accesses", 10'h008, w);

    // R6: one-shot configuration flag
    do_write(10'h004, 32'h1, w);
    do_read("R6 armed flag reads zero", 10'h004, w);
    do_read("R6 config read value", 10'h00C, w);
    do_read("R6 following read is I/O", 10'h00C, w);
    do_write(10'h004, 32'h1, w);
    do_write(10'h00C, 32'h0000_0013, w);
    do_write(10'h004, 32'h1, w);
    do_write(10'h004, 32'h0, w);
    do_read("R6 disarmed read is I/O", 10'h00C, w);

    // R7: aliasing across the window
    do_write(10'h3F8, 32'h0000_2C20, w);
    do_read("R7 alias 0x3F8 to address reg", 10'h008, w);
    do_read("R7 alias 0x38 reads address reg", 10'h038, w);
    do_read("R7 alias 0x3FC data read", 10'h3FC, w);
    do_write(10'h034, 32'h1, w);
    do_read("R7 alias 0x34 arms config", 10'h00C, w);

    // R8: unused offsets
    do_write(10'h000, 32'hFFFF_FFFF, w);
    check("R8 unused write accept waits", w, 0);
    do_read("R8 unused offset reads zero", 10'h000, w);
    do_write(10'h02C, 32'hFFFF_FFFF, w);
    do_read("R8 address unchanged by unused write", 10'h008, w);
    do_read("R8 offset 0x10 reads zero", 10'h010, w);
    do_read("R8 offset 0x3F0 reads zero", 10'h3F0, w);

    // R5: second posted write stalls until the first drains
    lat = 3;
    do_write(10'h00C, 32'hAAAA_0001, w);
    check("R5 first posted write waits", w, 0);
    do_write(10'h00C, 32'hAAAA_0002, w);
    check("R5 second posted write stall", w, 4);
    do_read("R5 read after posted write", 10'h00C, w);
    repeat (12) @(negedge clk);

    // R9: every expected downstream cycle was observed
    check("R9 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule